// File: doc/BRIEF.md
# Single-Wire Pulse Bit Codec

This block moves bytes over one open-drain data line that idles high. A bit occupies a fixed window. The window always opens with a short low pulse. A one is that pulse alone, with the line released for the rest of the window. A zero adds a second short low pulse, placed after a high gap of the same width. The pulse unit matches one bit time of a 230.4 kBaud UART frame of seven data bits, no parity and one stop bit. This lets a host build each bit from a single UART character.

The transmit side takes bytes through a valid/ready port and sends them least significant bit first. It drives the line only by asserting an output enable that pulls low. The receive side synchronises the line and times each bit from the falling edge that opens it. It then shifts recovered bits into bytes and offers them on a valid/ready port. The block leaves a turnaround gap after the last received bit before it starts sending. It also raises a timeout flag when the line stays quiet too long. All durations are parameters in clock cycles.

Top module: `swi_bit_codec`

## Requirements
- R1: After reset, line_oe and rx_valid are 0, timeout_o is 0 and tx_ready is 1.
- R2: A transmitted 1 pulls the line low (line_oe=1) for exactly PULSE_CYC cycles at the start of a TX_BIT_CYC-cycle window, then releases it for the rest of the window.
- R3: A transmitted 0 asserts line_oe for PULSE_CYC cycles, releases it for PULSE_CYC cycles, asserts it for PULSE_CYC cycles more, and releases it for the rest of the window.
- R4: A byte accepted on tx_data (handshake when tx_valid and tx_ready are 1 at a clock edge) goes out as 8 windows, bit 0 first. line_oe rises in the cycle after the handshake. tx_ready stays 0 until the 8th window ends.
- R5: On receive, a bit is 0 when a second falling edge follows the opening falling edge within ZERO_WIN_CYC cycles, and 1 otherwise.
- R6: Eight received bits, the first in bit 0 of rx_data, form a byte, which raises rx_valid. rx_valid and rx_data hold until rx_ready is 1 at an edge. A byte that completes while rx_valid is still 1 is discarded.
- R7: tx_ready stays 0 until TURN_CYC cycles have passed since the opening falling edge of the last received bit.
- R8: While a byte is being transmitted, the receiver ignores the line, so its own pulses produce no received data.
- R9: timeout_o rises after IDLE_TMO_CYC cycles with no falling edge on the line and no transmission. A falling edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter accepts a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a new byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| line_i | input | 1 | Raw level of the data line |
| line_oe | output | 1 | 1 pulls the data line low |
| timeout_o | output | 1 | Line inactive longer than the timeout |

## Verification
The bench builds the block with a 4-cycle pulse unit, a 12-cycle zero window, a 48-cycle transmit window, an 88-cycle turnaround and a 600-cycle timeout. It keeps the real ratios between pulse, window and turnaround, so every transmitted window can be compared cycle by cycle. A host bit of 36 cycles is short enough to send whole bytes and to observe the turnaround. The reduced timeout brings the inactivity flag, and its clearing by a new edge, within a short run. Looping line_oe back onto line_i exercises the receive gating during transmission.

// File: rtl/swi_codec_pkg.sv
package swi_codec_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_MEAS = 1'b1
    } rx_state_e;
endpackage

// File: rtl/swi_sync.sv
module swi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b1;
                else        stage_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '1;
                else        stage_q <= {stage_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/swi_rx.sv
module swi_rx
    import swi_codec_pkg::*;
#(
    parameter int ZERO_WIN_CYC = 651
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    input  logic              gate_i,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              start_fall_o,
    output logic              any_fall_o
);
    localparam int CW = $clog2(ZERO_WIN_CYC + 1);

    typedef struct packed {
        rx_state_e         st;
        logic              prev;
        logic [CW-1:0]     cnt;
        logic              zero;
        logic [BYTE_W-1:0] shreg;
        logic [IDX_W-1:0]  nbits;
        logic [BYTE_W-1:0] data;
        logic              valid;
    } rx_reg_t;

    rx_reg_t q, d;
    logic    fall;
    logic    bit_val;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        d            = q;
        d.prev       = line_s;
        fall         = q.prev & ~line_s;
        start_fall_o = 1'b0;
        bit_val      = 1'b1;
        shifted      = q.shreg;

        if (q.valid && rx_ready) d.valid = 1'b0;

        if (gate_i) begin
            d.st    = RX_IDLE;
            d.nbits = '0;
        end else begin
            case (q.st)
                RX_IDLE: begin
                    if (fall) begin
                        d.st         = RX_MEAS;
                        d.cnt        = '0;
                        d.zero       = 1'b0;
                        start_fall_o = 1'b1;
                    end
                end
                default: begin
                    d.cnt = q.cnt + 1'b1;
                    if (fall) d.zero = 1'b1;
                    if (q.cnt == CW'(ZERO_WIN_CYC - 1)) begin
                        d.st    = RX_IDLE;
                        bit_val = ~(q.zero | fall);
                        shifted = {bit_val, q.shreg[BYTE_W-1:1]};
                        d.shreg = shifted;
                        d.nbits = q.nbits + 1'b1;
                        if (q.nbits == IDX_W'(BYTE_W - 1)) begin
                            if (!d.valid) begin
                                d.data  = shifted;
                                d.valid = 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= RX_IDLE;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data    = q.data;
    assign rx_valid   = q.valid;
    assign any_fall_o = fall;
endmodule

// File: rtl/swi_tx.sv
module swi_tx
    import swi_codec_pkg::*;
#(
    parameter int PULSE_CYC  = 217,
    parameter int TX_BIT_CYC = 2700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              allow_i,
    output logic              tx_ready,
    output logic              line_oe,
    output logic              busy_o
);
    localparam int CW = $clog2(TX_BIT_CYC + 1);

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] shreg;
    } tx_reg_t;

    tx_reg_t q, d;

    assign tx_ready = ~q.busy & allow_i;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (tx_valid && tx_ready) begin
                d.busy  = 1'b1;
                d.cnt   = '0;
                d.idx   = '0;
                d.shreg = tx_data;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(TX_BIT_CYC - 1)) begin
                d.cnt   = '0;
                d.shreg = {1'b0, q.shreg[BYTE_W-1:1]};
                d.idx   = q.idx + 1'b1;
                if (q.idx == IDX_W'(BYTE_W - 1)) d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        line_oe = 1'b0;
        if (q.busy) begin
            if (q.cnt < CW'(PULSE_CYC))
                line_oe = 1'b1;
            else if (!q.shreg[0] && q.cnt >= CW'(2 * PULSE_CYC) && q.cnt < CW'(3 * PULSE_CYC))
                line_oe = 1'b1;
        end
    end

    assign busy_o = q.busy;
endmodule

// File: rtl/swi_link_timer.sv
module swi_link_timer #(
    parameter int TURN_CYC     = 4800,
    parameter int IDLE_TMO_CYC = 3250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_fall_i,
    input  logic any_fall_i,
    input  logic tx_busy_i,
    output logic gap_ok_o,
    output logic timeout_o
);
    localparam int GW = $clog2(TURN_CYC + 1);
    localparam int IW = $clog2(IDLE_TMO_CYC + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [IW-1:0] idle;
    } tmr_reg_t;

    tmr_reg_t q, d;

    always_comb begin
        d = q;
        if (start_fall_i)
            d.gap = '0;
        else if (q.gap != GW'(TURN_CYC))
            d.gap = q.gap + 1'b1;

        if (any_fall_i || tx_busy_i)
            d.idle = '0;
        else if (q.idle != IW'(IDLE_TMO_CYC))
            d.idle = q.idle + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.gap  <= GW'(TURN_CYC);
            q.idle <= '0;
        end else begin
            q <= d;
        end
    end

    assign gap_ok_o  = (q.gap == GW'(TURN_CYC));
    assign timeout_o = (q.idle == IW'(IDLE_TMO_CYC));
endmodule

// File: rtl/swi_bit_codec.sv
module swi_bit_codec #(
    parameter int PULSE_CYC    = 217,
    parameter int ZERO_WIN_CYC = 651,
    parameter int TX_BIT_CYC   = 2700,
    parameter int TURN_CYC     = 4800,
    parameter int IDLE_TMO_CYC = 3250000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    input  logic       line_i,
    output logic       line_oe,
    output logic       timeout_o
);
    logic line_s;
    logic tx_busy;
    logic gap_ok;
    logic start_fall;
    logic any_fall;

    swi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (line_s)
    );

    swi_rx #(.ZERO_WIN_CYC(ZERO_WIN_CYC)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_s       (line_s),
        .gate_i       (tx_busy),
        .rx_ready     (rx_ready),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .start_fall_o (start_fall),
        .any_fall_o   (any_fall)
    );

    swi_tx #(.PULSE_CYC(PULSE_CYC), .TX_BIT_CYC(TX_BIT_CYC)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .allow_i  (gap_ok),
        .tx_ready (tx_ready),
        .line_oe  (line_oe),
        .busy_o   (tx_busy)
    );

    swi_link_timer #(.TURN_CYC(TURN_CYC), .IDLE_TMO_CYC(IDLE_TMO_CYC)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_fall_i (start_fall),
        .any_fall_i   (any_fall),
        .tx_busy_i    (tx_busy),
        .gap_ok_o     (gap_ok),
        .timeout_o    (timeout_o)
    );
endmodule

// File: rtl/swi_bit_codec_chk.sv
module swi_bit_codec_chk #(
    parameter int PULSE_CYC = 217
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_ready,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       line_oe
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (line_oe) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // R2 R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> run_q == 32'(PULSE_CYC));

    // R4
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> !tx_ready);

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R8
    no_rx_during_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> !line_oe);
endmodule

bind swi_bit_codec swi_bit_codec_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .line_oe  (line_oe)
);

// File: tb/swi_bit_codec_tb.sv
`timescale 1ns/1ps
module swi_bit_codec_tb;
    localparam int P    = 4;
    localparam int ZW   = 12;
    localparam int TXB  = 48;
    localparam int TURN = 88;
    localparam int TMO  = 600;
    localparam int HBIT = 36;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       host_line = 1'b1;
    logic       loop_en = 1'b0;
    logic       line_i;
    logic       line_oe;
    logic       timeout_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_start = 0;

    assign line_i = host_line & ~(loop_en & line_oe);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    swi_bit_codec #(
        .PULSE_CYC(P), .ZERO_WIN_CYC(ZW), .TX_BIT_CYC(TXB),
        .TURN_CYC(TURN), .IDLE_TMO_CYC(TMO), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .line_i(line_i), .line_oe(line_oe),
        .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_bit(input bit b);
        @(negedge clk);
        host_line = 1'b0;
        last_start = cyc;
        wait_neg(P);
        host_line = 1'b1;
        wait_neg(P);
        if (!b) begin
            host_line = 1'b0;
            wait_neg(P);
            host_line = 1'b1;
            wait_neg(HBIT - 3 * P - 1);
        end else begin
            wait_neg(HBIT - 2 * P - 1);
        end
    endtask

    task automatic host_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) host_bit(v[i]);
    endtask

    task automatic test_reset;
        // R1
        chk(line_oe == 1'b0, "R1 line_oe", line_oe, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(timeout_o == 1'b0, "R1 timeout_o", timeout_o, 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    endtask

    task automatic test_tx(input logic [7:0] v);
        int bad;
        bit mid_ready;
        int w;
        w = 0;
        @(negedge clk);
        while (!tx_ready && w < 1000) begin @(negedge clk); w++; end
        tx_data = v;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        mid_ready = 1'b0;
        for (int bi = 0; bi < 8; bi++) begin
            bad = 0;
            for (int j = 0; j < TXB; j++) begin
                bit e;
                e = (j < P) || (!v[bi] && j >= 2 * P && j < 3 * P);
                if (line_oe !== e) bad++;
                if (tx_ready) mid_ready = 1'b1;
                @(negedge clk);
            end
            // R2 R3: one window per bit, bit 0 first (R4)
            chk(bad == 0, v[bi] ? "R2 window of a 1 (R4 order)" : "R3 window of a 0 (R4 order)", bad, 0);
        end
        // R4
        chk(!mid_ready, "R4 tx_ready low while sending", mid_ready, 0);
        chk(tx_ready == 1'b1 && line_oe == 1'b0, "R4 ready after 8 windows", tx_ready, 1);
        // R8
        chk(rx_valid == 1'b0, "R8 no rx during own tx", rx_valid, 0);
    endtask

    task automatic test_rx;
        host_byte(8'hA5);
        wait_neg(2);
        // R5 R6
        chk(rx_valid == 1'b1, "R6 rx_valid after byte", rx_valid, 1);
        chk(rx_data == 8'hA5, "R5 R6 rx_data A5", rx_data, 8'hA5);
        wait_neg(40);
        chk(rx_valid == 1'b1 && rx_data == 8'hA5, "R6 held without rx_ready", rx_data, 8'hA5);
        host_byte(8'h3C);
        wait_neg(2);
        chk(rx_data == 8'hA5, "R6 pending byte not overwritten", rx_data, 8'hA5);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(rx_valid == 1'b0, "R6 rx_valid clears on rx_ready", rx_valid, 0);
    endtask

    task automatic test_turnaround;
        int w;
        host_byte(8'h0F);
        wait_neg(1);
        chk(rx_data == 8'h0F && rx_valid, "R5 rx_data 0F", rx_data, 8'h0F);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        // R7
        chk(tx_ready == 1'b0, "R7 tx_ready low inside gap", tx_ready, 0);
        w = 0;
        while (!tx_ready && w < 1000) begin @(negedge clk); w++; end
        chk((cyc - last_start) >= TURN && (cyc - last_start) <= TURN + 4,
            "R7 gap length", cyc - last_start, TURN + 3);
    endtask

    task automatic test_timeout;
        host_byte(8'hFF);
        wait_neg(TMO - 120);
        // R9
        chk(timeout_o == 1'b0, "R9 no timeout early", timeout_o, 0);
        wait_neg(160);
        chk(timeout_o == 1'b1, "R9 timeout after idle", timeout_o, 1);
        host_line = 1'b0;
        wait_neg(5);
        chk(timeout_o == 1'b0, "R9 cleared by falling edge", timeout_o, 0);
        host_line = 1'b1;
        wait_neg(40);
    endtask

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        test_reset();
        loop_en = 1'b1;
        test_tx(8'hA5);
        test_tx(8'h3C);
        loop_en = 1'b0;
        test_rx();
        test_turnaround();
        test_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule